// File: doc/BRIEF.md
# Shared-Line TDM Slot Transmitter

This block serializes per-channel measurement words onto one TDM data line that is wired to the outputs of several other transmitters. Each frame holds 16 slots of 32 bits (512 bit periods). The block drives the line only in the bit periods it owns. In every other bit period it drops its output enable, so an external three-state buffer releases the pin and another device can drive the line.

Four data groups feed the transmitter: group 0 is predicted voltage, group 1 is sensed current, and groups 2 and 3 are auxiliary. Each group has four channels. Each group is placed in the frame by its own start position. That position is built from a high part and a low byte. The high parts of all groups come from one shared configuration word, and each group keeps its own low byte. A per-group channel mask picks which channels are sent. The enabled channels fill consecutive slots starting at the group's start position. A word-length code sets how many leading bits of each 32-bit word are sent. The bit clock can be used as is or inverted.

A frame sequencer with three states (FR_IDLE, FR_RUN, FR_DONE) tracks the bit position. The transitions are:
- FR_IDLE to FR_RUN on a frame-sync rise.
- FR_RUN to FR_DONE after bit 511.
- FR_DONE to FR_RUN on the next rise.
- FR_RUN to FR_RUN (restart at bit 0) on a rise in mid-frame.

Top module: `tdm_slot_tx`

## Requirements
- R1: While reset is low, `sd_oe`, `sd_out` and `sd_overlap` are 0. After reset they stay 0 until the first frame-sync rise.
- R2: A frame starts when `fsync` is sampled 1 on a launch edge after being sampled 0 on the edge before. Bit 0 is presented in the bit period that begins at that edge. A new rise during a frame restarts the frame at bit 0.
- R3: A frame lasts 512 bit periods. After bit 511 the line stays released until the next frame-sync rise.
- R4: The start position of group g is `cfg_ofs_msb[g]`*256 + `cfg_ofs_lsb[8g+7:8g]`. Its enabled channels occupy 32-bit slots from that position onward. For example, starts of 0, 128, 256 and 384 with four channels land on slots 1–4, 5–8, 9–12 and 13–16.
- R5: A group whose start position is all ones (511) is never driven.
- R6: Channel c of group g is enabled by `cfg_ch_en[4g+c]`. Enabled channels are packed in ascending channel order into consecutive slots. Disabled channels use no slot.
- R7: The word of group g, channel c is `smp_words[32(4g+c)+31 : 32(4g+c)]`. It is sent MSB first. Word-length code `cfg_wlen` 0 sends 16 bits, 1 sends 24 bits, and 2 or 3 sends 32 bits. The rest of the slot is driven 0 with `sd_oe` high.
- R8: `sd_oe` is high exactly in owned bit periods. `sd_oe` and `sd_out` change together on the launch edge.
- R9: With `cfg_bclk_inv` = 0 the launch edge is the rising edge of `bclk`. With `cfg_bclk_inv` = 1 it is the falling edge.
- R10: Words are captured at frame start. A change on `smp_words` during a frame has no effect until the next frame.
- R11: When enabled groups claim the same bit period, the lowest-numbered group drives it and `sd_overlap` is high for that bit period.
- R12: Group bits that would fall beyond bit 511 are never driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fsync | input | 1 | Frame sync; a rise starts a frame |
| cfg_bclk_inv | input | 1 | Selects the falling edge of `bclk` as the launch edge |
| cfg_ofs_msb | input | 4 | Shared word of high position bits, one per group |
| cfg_ofs_lsb | input | 32 | Low start byte of each group, 8 bits per group |
| cfg_wlen | input | 2 | Word-length code |
| cfg_ch_en | input | 16 | Channel enable masks, 4 bits per group |
| smp_words | input | 512 | Measurement words, 32 bits per group and channel |
| sd_oe | output | 1 | Drive enable for the external three-state pin |
| sd_out | output | 1 | Serial data bit |
| sd_overlap | output | 1 | Two or more groups claim the current bit period |

## Verification
Every output bit is registered once. The enable, data and overlap values for position p therefore appear in the bit period that starts at the launch edge where the sequencer stands at p. For bit 0 this is the edge where the frame-sync rise is sampled. The bench waits on the launch edge of the chosen polarity and samples a quarter period after it. It then changes `fsync` and `smp_words` at that same point, so every stimulus is seen on the next launch edge. The expected enable, data and overlap for each position are computed from the requirements using a snapshot of the words taken at frame start. The release checks run for several bit periods before the first frame and after bit 511.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_RUN  = 2'd1,
        FR_DONE = 2'd2
    } frame_state_e;

    // number of leading word bits sent per slot for a word-length code
    function automatic int unsigned word_bits(input logic [1:0] code, input int unsigned slot_w);
        case (code)
            2'd0:    return slot_w / 2;
            2'd1:    return (slot_w * 3) / 4;
            default: return slot_w;
        endcase
    endfunction

endpackage

// File: rtl/tdm_frame_ctrl.sv
module tdm_frame_ctrl
    import tdm_tx_pkg::*;
#(
    parameter int FRAME_BITS = 512,
    parameter int POS_W      = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync,
    output logic [POS_W-1:0] pos,
    output logic             pos_vld,
    output logic             frame_start,
    output frame_state_e     state
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

    logic             fsync_q;
    frame_state_e     st_q, st_d;
    logic [POS_W-1:0] cnt_q, cnt_d;

    assign frame_start = fsync & ~fsync_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= FR_IDLE;
            cnt_q   <= '0;
            fsync_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            cnt_q   <= cnt_d;
            fsync_q <= fsync;
        end
    end

    // next state
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (frame_start) begin
            st_d  = FR_RUN;
            cnt_d = POS_W'(1);
        end else begin
            unique case (st_q)
                FR_IDLE: st_d = FR_IDLE;
                FR_RUN: begin
                    if (cnt_q == LAST_POS) st_d = FR_DONE;
                    else                   cnt_d = cnt_q + POS_W'(1);
                end
                FR_DONE: st_d = FR_DONE;
                default: st_d = FR_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        pos     = frame_start ? '0 : cnt_q;
        pos_vld = frame_start | (st_q == FR_RUN);
        state   = st_q;
    end

endmodule

// File: rtl/tdm_slot_map.sv
module tdm_slot_map #(
    parameter int NUM_CH = 4,
    parameter int SLOT_W = 32,
    parameter int POS_W  = 9,
    parameter int CH_W   = 2,
    parameter int BIT_W  = 5
) (
    input  logic [POS_W-1:0]  pos,
    input  logic              pos_vld,
    input  logic [POS_W-1:0]  ofs,
    input  logic [NUM_CH-1:0] ch_en,
    output logic              own,
    output logic              grp_off,
    output logic [CH_W-1:0]   ch_idx,
    output logic [BIT_W-1:0]  bit_idx
);

    localparam int SN_W = POS_W - BIT_W + 1;

    logic [POS_W:0]    rel;
    logic [SN_W-1:0]   slot_no;
    logic [SN_W-1:0]   seen;
    logic              past_start;

    always_comb begin
        grp_off    = &ofs;
        rel        = {1'b0, pos} - {1'b0, ofs};
        past_start = (pos >= ofs);
        slot_no    = rel[POS_W:BIT_W];
        bit_idx    = rel[BIT_W-1:0];
        own        = 1'b0;
        ch_idx     = '0;
        seen       = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_en[c]) begin
                if (seen == slot_no) begin
                    own    = pos_vld & ~grp_off & past_start;
                    ch_idx = CH_W'(c);
                end
                seen = seen + SN_W'(1);
            end
        end
    end

endmodule

// File: rtl/tdm_out_mux.sv
module tdm_out_mux
    import tdm_tx_pkg::*;
#(
    parameter int NUM_GROUPS = 4,
    parameter int NUM_CH     = 4,
    parameter int SLOT_W     = 32,
    parameter int CH_W       = 2,
    parameter int BIT_W      = 5,
    localparam int WORDS_W   = NUM_GROUPS * NUM_CH * SLOT_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_GROUPS-1:0]      own,
    input  logic [NUM_GROUPS*CH_W-1:0] ch_idx,
    input  logic [NUM_GROUPS*BIT_W-1:0] bit_idx,
    input  logic [WORDS_W-1:0]         words,
    input  logic [1:0]                 wlen,
    output logic                       sd_oe,
    output logic                       sd_out,
    output logic                       sd_overlap
);

    logic              any_own;
    logic              bit_val;
    logic              multi;
    logic [SLOT_W-1:0] word;
    logic [CH_W-1:0]   ci;
    logic [BIT_W-1:0]  bi;
    int unsigned       wl;
    int                wi;

    // lowest group index is visited last and so wins
    always_comb begin
        any_own = 1'b0;
        bit_val = 1'b0;
        word    = '0;
        ci      = '0;
        bi      = '0;
        wi      = 0;
        wl      = word_bits(wlen, SLOT_W);
        for (int g = NUM_GROUPS - 1; g >= 0; g--) begin
            if (own[g]) begin
                any_own = 1'b1;
                ci      = ch_idx[g*CH_W +: CH_W];
                bi      = bit_idx[g*BIT_W +: BIT_W];
                wi      = g * NUM_CH + int'(ci);
                word    = words[wi*SLOT_W +: SLOT_W];
                bit_val = (32'(bi) < wl) ? word[SLOT_W-1-int'(bi)] : 1'b0;
            end
        end
        multi = ($countones(own) > 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sd_oe      <= 1'b0;
            sd_out     <= 1'b0;
            sd_overlap <= 1'b0;
        end else begin
            sd_oe      <= any_own;
            sd_out     <= any_own & bit_val;
            sd_overlap <= multi;
        end
    end

endmodule

// File: rtl/tdm_slot_tx.sv
module tdm_slot_tx
    import tdm_tx_pkg::*;
#(
    parameter int NUM_GROUPS = 4,
    parameter int NUM_CH     = 4,
    parameter int SLOT_W     = 32,
    parameter int NUM_SLOTS  = 16,
    parameter int LSB_W      = 8,
    localparam int FRAME_BITS = SLOT_W * NUM_SLOTS,
    localparam int POS_W      = $clog2(FRAME_BITS),
    localparam int HI_W       = POS_W - LSB_W,
    localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int BIT_W      = $clog2(SLOT_W),
    localparam int WORDS_W    = NUM_GROUPS * NUM_CH * SLOT_W
) (
    input  logic                        bclk,
    input  logic                        rst_n,
    input  logic                        fsync,
    input  logic                        cfg_bclk_inv,
    input  logic [NUM_GROUPS*HI_W-1:0]  cfg_ofs_msb,
    input  logic [NUM_GROUPS*LSB_W-1:0] cfg_ofs_lsb,
    input  logic [1:0]                  cfg_wlen,
    input  logic [NUM_GROUPS*NUM_CH-1:0] cfg_ch_en,
    input  logic [WORDS_W-1:0]          smp_words,
    output logic                        sd_oe,
    output logic                        sd_out,
    output logic                        sd_overlap
);

    logic                        launch_clk;
    logic [POS_W-1:0]            pos;
    logic                        pos_vld;
    logic                        frame_start;
    frame_state_e                fr_state;
    logic [WORDS_W-1:0]          held_words;
    logic [WORDS_W-1:0]          cur_words;
    logic [NUM_GROUPS-1:0]       grp_own;
    logic [NUM_GROUPS-1:0]       grp_off;
    logic [NUM_GROUPS*CH_W-1:0]  grp_ch;
    logic [NUM_GROUPS*BIT_W-1:0] grp_bit;

    assign launch_clk = bclk ^ cfg_bclk_inv;

    tdm_frame_ctrl #(
        .FRAME_BITS (FRAME_BITS),
        .POS_W      (POS_W)
    ) u_frame (
        .clk         (launch_clk),
        .rst_n       (rst_n),
        .fsync       (fsync),
        .pos         (pos),
        .pos_vld     (pos_vld),
        .frame_start (frame_start),
        .state       (fr_state)
    );

    // words are frozen for the whole frame
    always_ff @(posedge launch_clk or negedge rst_n) begin
        if (!rst_n)           held_words <= '0;
        else if (frame_start) held_words <= smp_words;
    end

    assign cur_words = frame_start ? smp_words : held_words;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        tdm_slot_map #(
            .NUM_CH (NUM_CH),
            .SLOT_W (SLOT_W),
            .POS_W  (POS_W),
            .CH_W   (CH_W),
            .BIT_W  (BIT_W)
        ) u_map (
            .pos     (pos),
            .pos_vld (pos_vld),
            .ofs     ({cfg_ofs_msb[g*HI_W +: HI_W], cfg_ofs_lsb[g*LSB_W +: LSB_W]}),
            .ch_en   (cfg_ch_en[g*NUM_CH +: NUM_CH]),
            .own     (grp_own[g]),
            .grp_off (grp_off[g]),
            .ch_idx  (grp_ch[g*CH_W +: CH_W]),
            .bit_idx (grp_bit[g*BIT_W +: BIT_W])
        );
    end

    tdm_out_mux #(
        .NUM_GROUPS (NUM_GROUPS),
        .NUM_CH     (NUM_CH),
        .SLOT_W     (SLOT_W),
        .CH_W       (CH_W),
        .BIT_W      (BIT_W)
    ) u_mux (
        .clk        (launch_clk),
        .rst_n      (rst_n),
        .own        (grp_own),
        .ch_idx     (grp_ch),
        .bit_idx    (grp_bit),
        .words      (cur_words),
        .wlen       (cfg_wlen),
        .sd_oe      (sd_oe),
        .sd_out     (sd_out),
        .sd_overlap (sd_overlap)
    );

endmodule

// File: rtl/tdm_slot_tx_chk.sv
module tdm_slot_tx_chk
    import tdm_tx_pkg::*;
#(
    parameter int NUM_GROUPS = 4,
    parameter int WORDS_W    = 512
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  frame_start,
    input logic                  pos_vld,
    input frame_state_e          fr_state,
    input logic [NUM_GROUPS-1:0] own,
    input logic [NUM_GROUPS-1:0] grp_off,
    input logic [WORDS_W-1:0]    held,
    input logic                  sd_oe,
    input logic                  sd_overlap
);

    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_quiet: assert (!sd_oe && !sd_overlap);
        end
    end

    a_r2_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (fr_state == FR_RUN));

    a_r3_release_outside: assert property (@(posedge clk) disable iff (!rst_n)
        !pos_vld |=> !sd_oe);

    a_r5_all_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (&grp_off) |=> !sd_oe);

    a_r8_owner_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (|own) |=> sd_oe);

    a_r10_words_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(held));

    a_r11_overlap_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(own) > 1) |=> sd_overlap);

    a_r11_no_false_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(own) < 2) |=> !sd_overlap);

endmodule

bind tdm_slot_tx tdm_slot_tx_chk #(
    .NUM_GROUPS (NUM_GROUPS),
    .WORDS_W    (WORDS_W)
) u_chk (
    .clk         (launch_clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .pos_vld     (pos_vld),
    .fr_state    (fr_state),
    .own         (grp_own),
    .grp_off     (grp_off),
    .held        (held_words),
    .sd_oe       (sd_oe),
    .sd_overlap  (sd_overlap)
);

// File: tb/tb_tdm_slot_tx.sv
module tb_tdm_slot_tx;

    localparam int PERIOD = 10;

    logic         bclk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fsync = 1'b0;
    logic         t_inv = 1'b0;
    logic [3:0]   t_msb = '1;
    logic [31:0]  t_lsb = '1;
    logic [1:0]   t_wlen = 2'd2;
    logic [15:0]  t_en = '1;
    logic [511:0] t_words = '0;
    logic [511:0] snap = '0;
    logic         sd_oe, sd_out, sd_overlap;

    int n_checks = 0;
    int n_fail   = 0;

    always #(PERIOD/2) bclk = ~bclk;

    tdm_slot_tx dut (
        .bclk         (bclk),
        .rst_n        (rst_n),
        .fsync        (fsync),
        .cfg_bclk_inv (t_inv),
        .cfg_ofs_msb  (t_msb),
        .cfg_ofs_lsb  (t_lsb),
        .cfg_wlen     (t_wlen),
        .cfg_ch_en    (t_en),
        .smp_words    (t_words),
        .sd_oe        (sd_oe),
        .sd_out       (sd_out),
        .sd_overlap   (sd_overlap)
    );

    task automatic check3(input string req, input int p, input logic [2:0] act, input logic [2:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s bit=%0d actual oe/out/ovl=%b expected=%b", req, p, act, exp);
        end
    endtask

    task automatic wait_launch();
        if (t_inv) @(negedge bclk);
        else       @(posedge bclk);
    endtask

    // expected {oe, out, overlap} for frame position p
    function automatic logic [2:0] model(input int p);
        int owners = 0;
        logic oe = 1'b0;
        logic d = 1'b0;
        for (int g = 0; g < 4; g++) begin
            int off = int'(t_msb[g]) * 256 + int'(t_lsb[g*8 +: 8]);
            int n = 0;
            int chans[4];
            for (int c = 0; c < 4; c++) if (t_en[g*4+c]) begin chans[n] = c; n++; end
            if (off != 511 && p >= off && p < off + 32*n) begin
                owners++;
                if (owners == 1) begin
                    int k = (p - off) / 32;
                    int b = (p - off) % 32;
                    int wl = (t_wlen == 2'd0) ? 16 : (t_wlen == 2'd1) ? 24 : 32;
                    logic [31:0] w = snap[(g*4 + chans[k])*32 +: 32];
                    oe = 1'b1;
                    d  = (b < wl) ? w[31-b] : 1'b0;
                end
            end
        end
        return {oe, d, (owners > 1)};
    endfunction

    task automatic run_frame(input int nbits, input string req, input int chg_at);
        fsync = 1'b1;
        for (int p = 0; p < nbits; p++) begin
            wait_launch();
            if (p == 0) snap = t_words;
            #(PERIOD/4);
            fsync = 1'b0;
            check3(req, p, {sd_oe, sd_out, sd_overlap}, model(p));
            if (p == chg_at) t_words = ~t_words ^ {16{32'h3C5A_9617}};
        end
    endtask

    task automatic idle_bits(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            wait_launch();
            #(PERIOD/4);
            check3(req, -1, {sd_oe, sd_out, sd_overlap}, 3'b000);
        end
    endtask

    task automatic do_reset(input logic inv);
        rst_n = 1'b0;
        fsync = 1'b0;
        #(PERIOD);
        t_inv = inv;
        #(PERIOD*2);
        check3("R1", -1, {sd_oe, sd_out, sd_overlap}, 3'b000);
        wait_launch();
        #(PERIOD/4);
        rst_n = 1'b1;
    endtask

    task automatic set_grp(input int g, input logic hi, input logic [7:0] lsb, input logic [3:0] mask);
        t_msb[g]         = hi;
        t_lsb[g*8 +: 8]  = lsb;
        t_en[g*4 +: 4]   = mask;
    endtask

    task automatic all_off();
        for (int g = 0; g < 4; g++) set_grp(g, 1'b1, 8'hFF, 4'hF);
    endtask

    task automatic fill_words(input logic [31:0] seed);
        for (int i = 0; i < 16; i++) t_words[i*32 +: 32] = (32'h9E37_79B9 * (i + 1)) ^ seed;
    endtask

    initial begin
        #(PERIOD*150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        fill_words(32'h0F1E_2D3C);
        all_off();
        do_reset(1'b0);
        // R1: quiet before any frame sync
        idle_bits(8, "R1");

        // R4: sensed-current group moved through the four quarters of the frame
        for (int d = 0; d < 4; d++) begin
            all_off();
            set_grp(1, d[1], {d[0], 7'b0}, 4'hF);
            run_frame(512, "R4", -1);
        end
        // R3: released after bit 511
        idle_bits(6, "R3");

        // R5: every group at all ones
        all_off();
        run_frame(512, "R5", -1);

        // R8/R7: all four groups tile the frame, full words
        fill_words(32'hA5A5_5A5A);
        set_grp(0, 1'b0, 8'h00, 4'hF);
        set_grp(1, 1'b0, 8'h80, 4'hF);
        set_grp(2, 1'b1, 8'h00, 4'hF);
        set_grp(3, 1'b1, 8'h80, 4'hF);
        run_frame(512, "R8", -1);

        // R7: short word lengths
        t_wlen = 2'd0;
        run_frame(512, "R7", -1);
        t_wlen = 2'd1;
        run_frame(512, "R7", -1);
        t_wlen = 2'd3;
        run_frame(512, "R7", -1);
        t_wlen = 2'd2;

        // R6: sparse channel masks packed into consecutive slots
        all_off();
        set_grp(0, 1'b0, 8'h05, 4'b1010);
        set_grp(1, 1'b0, 8'hC0, 4'b0101);
        set_grp(3, 1'b1, 8'h40, 4'b1000);
        run_frame(512, "R6", -1);

        // R11: group 0 and group 1 overlap on bits 64..127
        all_off();
        set_grp(0, 1'b0, 8'h00, 4'hF);
        set_grp(1, 1'b0, 8'h40, 4'h3);
        run_frame(512, "R11", -1);

        // R12: group starting at 500 is cut at the frame end
        all_off();
        set_grp(2, 1'b1, 8'hF4, 4'hF);
        run_frame(512, "R12", -1);
        idle_bits(4, "R3");

        // R10: words change during the frame
        set_grp(0, 1'b0, 8'h00, 4'hF);
        fill_words(32'h1357_9BDF);
        run_frame(512, "R10", 40);
        run_frame(512, "R10", -1);

        // R2: frame restarted part-way through
        run_frame(100, "R2", -1);
        run_frame(512, "R2", -1);

        // R9: inverted bit clock
        do_reset(1'b1);
        idle_bits(4, "R1");
        set_grp(1, 1'b0, 8'h80, 4'b0110);
        set_grp(3, 1'b1, 8'h80, 4'hF);
        run_frame(512, "R9", -1);
        do_reset(1'b0);

        // R4/R6: sweep the start of group 1 over the position range
        all_off();
        for (int k = 0; k < 32; k++) begin
            fill_words(32'hC0DE_0000 + 32'(k));
            set_grp(1, k[0], 8'((k * 37) & 8'hFF), 4'((k % 15) + 1));
            run_frame(512, "R4", -1);
        end
        set_grp(1, 1'b1, 8'hFF, 4'hF);
        run_frame(512, "R5", -1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule